// File: doc/BRIEF.md
# Extended Match Channel Bank

This block holds eight match channels, numbered 4 to 11, each with a 32-bit counter, a 32-bit match value and a control word. The control word picks the tick that advances the channel's counter. It also decides whether the channel compares against its own counter or against a counter shared by its group, whether a match clears the counter, and whether the channel keeps matching or matches only once. Channels 9 and 11 can also latch the count of their lower neighbour into a common snapshot register whenever software reads their counter.

Software reaches the bank through a plain register port with a write strobe and a read strobe. Read data is combinational while the read strobe is high. The prescaled tick enables arrive as single-cycle pulses from outside. Matches set per-channel status bits, gated by an enable register, and one interrupt line stays high while any of those status bits is set.

Top module: `mcb_bank`

## Requirements
- R1: Byte addresses: counter of channel n at 0x40+4*(n-4), match value at 0x80+4*(n-4), control word at 0xC0+4*(n-4), snapshot at 0x20, status at 0x14 and enable at 0x1C. In the status and enable registers, bit n (4..11) belongs to channel n. Read data is valid in the same cycle as the read strobe.
- R2: After reset every counter, match value, control word, status bit, enable bit and the snapshot read 0, and the interrupt is low.
- R3: Control bits [2:0] select the tick: 0 none, 1 the 32.768 kHz pulse, 2 the 1 kHz pulse, 3 the 1 Hz pulse, 4 the 1 MHz pulse, 5 the external pulse, 6 and 7 none. A counter gains 1 on each cycle in which its selected pulse is high.
- R4: A control write keeps bits [7:0] for channels 4 to 7 and bits [9:0] for channels 8 to 11. On channels 8 to 11, control bit 8 set stops the channel's counter whatever bits [2:0] say.
- R5: With control bit 7 set a channel compares against its own counter. With it clear, channels 4 to 7 compare against channel 4's counter, 8 and 9 against channel 8's, and 10 and 11 against channel 10's. In that case the channel's own counter counts only if the channel leads its group (4, 8, 10).
- R6: A match occurs when the compared counter advances by a tick to a value equal to the channel's match value while the channel is armed. A match sets the channel's status bit on the same clock edge if its enable bit is 1, and leaves it unchanged otherwise.
- R7: With control bit 3 set, a match loads 0 into the channel's own counter instead of the incremented value.
- R8: Writing a match value arms the channel. With control bit 6 clear, a match disarms it, so further passes produce no match until the match value is written again. With bit 6 set, the channel stays armed.
- R9: A read of channel 9's counter with its control bit 9 set copies channel 8's count into the snapshot register; channel 11 does the same with channel 10. Reads with bit 9 clear leave the snapshot unchanged.
- R10: Writing 1 to a status bit clears it and writing 0 leaves it. A match in the same cycle as a clear of the same bit leaves the bit set. The interrupt is high exactly when some status bit is set.
- R11: A counter write loads the written value, and wins over a tick or a zeroing match in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| tick32k | input | 1 | 32.768 kHz tick enable |
| tick1k | input | 1 | 1 kHz tick enable |
| tick1hz | input | 1 | 1 Hz tick enable |
| tick1m | input | 1 | 1 MHz tick enable |
| tickExt | input | 1 | External tick enable |
| status | output | 8 | Status bits of channels 4 to 11 |
| irq | output | 1 | Combined interrupt |

## Verification
A match that sets a status bit can fall on the same edge as a software write that clears that bit. The bench drives a one-cycle clear of two status bits together with the tick that completes a match on one of them. The matched bit must stay set, the other bit must clear, and the interrupt must remain high. A counter write that lands together with a tick is also provoked, and it is judged by the counter holding exactly the written value.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
  parameter int NUM_CH    = 8;
  parameter int FIRST_CH  = 4;
  parameter int CNT_W     = 32;
  parameter int CTRL_W    = 10;
  parameter int ADDR_W    = 8;
  parameter int NUM_SEL   = 8;
  localparam int IDX_W    = $clog2(NUM_CH);
  localparam int SEL_W    = $clog2(NUM_SEL);

  // control bit positions
  localparam int BIT_ZERO  = 3;
  localparam int BIT_REPT  = 6;
  localparam int BIT_OWN   = 7;
  localparam int BIT_HALT  = 8;
  localparam int BIT_SNAP  = 9;

  localparam logic [ADDR_W-1:0] SNAP_ADDR = 8'h20;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 8'h14;
  localparam logic [ADDR_W-1:0] EN_ADDR   = 8'h1C;
  localparam logic [1:0] REG_CNT   = 2'b01;
  localparam logic [1:0] REG_MATCH = 2'b10;
  localparam logic [1:0] REG_CTRL  = 2'b11;

  typedef struct packed {
    logic [NUM_CH-1:0] wrCnt;
    logic [NUM_CH-1:0] wrMatch;
    logic [NUM_CH-1:0] wrCtrl;
    logic [CNT_W-1:0]  data;
  } strobes_t;

  // group leader of a channel (index 0 is channel 4)
  function automatic int leaderOf(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 6) return 4;
    else              return 6;
  endfunction

  function automatic bit isWide(input int idx);
    return idx >= 4;
  endfunction

  function automatic bit isSnapCh(input int idx);
    return (idx >= 4) && (idx % 2 == 1);
  endfunction
endpackage

// File: rtl/mcb_datapath.sv
module mcb_datapath
  import mcb_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  strobes_t                       strb,
  input  logic [NUM_SEL-1:0]             srcTick,
  output logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
  output logic [NUM_CH-1:0][CNT_W-1:0]   matchVal,
  output logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl,
  output logic [NUM_CH-1:0]              matchEvt
);
  logic [NUM_CH-1:0] ownTick;

  for (genvar g = 0; g < NUM_CH; g++) begin : gCh
    localparam int  LEAD = leaderOf(g);
    localparam bit  WIDE = isWide(g);
    localparam bit  IS_LEAD = (LEAD == g);
    localparam logic [CTRL_W-1:0] KEEP = WIDE ? CTRL_W'(10'h3FF) : CTRL_W'(10'h0FF);

    logic [CNT_W-1:0]  cntQ;
    logic [CNT_W-1:0]  matchQ;
    logic [CTRL_W-1:0] ctrlQ;
    logic              armedQ;
    logic              halted;
    logic              useOwn;
    logic              cmpTick;
    logic              cmpWr;
    logic [CNT_W-1:0]  cmpCnt;
    logic              evt;

    assign halted  = WIDE && ctrlQ[BIT_HALT];
    assign useOwn  = ctrlQ[BIT_OWN] || IS_LEAD;
    assign ownTick[g] = useOwn && !halted && srcTick[ctrlQ[SEL_W-1:0]];
    assign cmpTick = useOwn ? ownTick[g] : ownTick[LEAD];
    assign cmpCnt  = useOwn ? cnt[g] : cnt[LEAD];
    assign cmpWr   = useOwn ? strb.wrCnt[g] : strb.wrCnt[LEAD];
    assign evt     = armedQ && cmpTick && !cmpWr && ((cmpCnt + CNT_W'(1)) == matchQ);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ   <= '0;
        matchQ <= '0;
        ctrlQ  <= '0;
        armedQ <= 1'b0;
      end else begin
        if (strb.wrCnt[g])                 cntQ <= strb.data;
        else if (evt && ctrlQ[BIT_ZERO])   cntQ <= '0;
        else if (ownTick[g])               cntQ <= cntQ + CNT_W'(1);

        if (strb.wrMatch[g]) begin
          matchQ <= strb.data;
          armedQ <= 1'b1;
        end else if (evt && !ctrlQ[BIT_REPT]) begin
          armedQ <= 1'b0;
        end

        if (strb.wrCtrl[g]) ctrlQ <= strb.data[CTRL_W-1:0] & KEEP;
      end
    end

    assign cnt[g]      = cntQ;
    assign matchVal[g] = matchQ;
    assign ctrl[g]     = ctrlQ;
    assign matchEvt[g] = evt;

    // R7: a zeroing match leaves the counter at 0
    assert_zero_on_match_R7: assert property (@(posedge clk) disable iff (!rstN)
      (evt && ctrlQ[BIT_ZERO] && !strb.wrCnt[g]) |=> (cntQ == '0));

    // R8: a one-shot match disarms the channel
    assert_oneshot_disarm_R8: assert property (@(posedge clk) disable iff (!rstN)
      (evt && !ctrlQ[BIT_REPT] && !strb.wrMatch[g]) |=> !armedQ);

    // R11: a counter write wins over everything else
    assert_cnt_write_R11: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrCnt[g] |=> (cntQ == $past(strb.data)));

    if (WIDE) begin : gHalt
      // R4: halt bit freezes the counter
      assert_halt_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
        (ctrlQ[BIT_HALT] && !strb.wrCnt[g] && !evt) |=> $stable(cntQ));
    end
  end
endmodule

// File: rtl/mcb_ctrl.sv
module mcb_ctrl
  import mcb_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  input  logic                           rdEn,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [CNT_W-1:0]               wdata,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   cnt,
  input  logic [NUM_CH-1:0][CNT_W-1:0]   matchVal,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]  ctrl,
  input  logic [NUM_CH-1:0]              matchEvt,
  output strobes_t                       strb,
  output logic [CNT_W-1:0]               rdata,
  output logic [NUM_CH-1:0]              status,
  output logic                           irq
);
  logic [1:0]        region;
  logic              slotOk;
  logic [IDX_W-1:0]  chIdx;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] statusNext;
  logic [NUM_CH-1:0] enQ;
  logic [NUM_CH-1:0] clrMask;
  logic [CNT_W-1:0]  snapQ;
  logic [CNT_W-1:0]  snapSrc;
  logic [NUM_CH-1:0] takeVec;
  logic              irqQ;

  assign region = addr[ADDR_W-1 -: 2];
  assign slotOk = !addr[5] && (addr[1:0] == 2'b00);
  assign chIdx  = addr[2 +: IDX_W];

  always_comb begin
    strb.data    = wdata;
    strb.wrCnt   = '0;
    strb.wrMatch = '0;
    strb.wrCtrl  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (wrEn && slotOk && (chIdx == IDX_W'(c))) begin
        strb.wrCnt[c]   = (region == REG_CNT);
        strb.wrMatch[c] = (region == REG_MATCH);
        strb.wrCtrl[c]  = (region == REG_CTRL);
      end
    end
  end

  // snapshot capture on counter reads of the odd wide channels
  for (genvar g = 0; g < NUM_CH; g++) begin : gSnap
    if (isSnapCh(g)) begin : gYes
      assign takeVec[g] = rdEn && slotOk && (region == REG_CNT) &&
                          (chIdx == IDX_W'(g)) && ctrl[g][BIT_SNAP];
      // R9: the snapshot holds the neighbour's count after a triggering read
      assert_snapshot_R9: assert property (@(posedge clk) disable iff (!rstN)
        takeVec[g] |=> (snapQ == $past(cnt[g-1])));
    end else begin : gNo
      assign takeVec[g] = 1'b0;
    end
  end

  always_comb begin
    snapSrc = snapQ;
    for (int c = 1; c < NUM_CH; c++) begin
      if (takeVec[c]) snapSrc = cnt[c-1];
    end
  end

  always_comb begin
    clrMask = '0;
    if (wrEn && (addr == STAT_ADDR)) clrMask = wdata[FIRST_CH +: NUM_CH];
    statusNext = (statusQ & ~clrMask) | (matchEvt & enQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enQ     <= '0;
      snapQ   <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      irqQ    <= |statusNext;
      snapQ   <= snapSrc;
      if (wrEn && (addr == EN_ADDR)) enQ <= wdata[FIRST_CH +: NUM_CH];
    end
  end

  always_comb begin
    rdata = '0;
    if (rdEn) begin
      if (addr == SNAP_ADDR)      rdata = snapQ;
      else if (addr == STAT_ADDR) rdata = CNT_W'(statusQ) << FIRST_CH;
      else if (addr == EN_ADDR)   rdata = CNT_W'(enQ) << FIRST_CH;
      else if (slotOk) begin
        case (region)
          REG_CNT:   rdata = cnt[chIdx];
          REG_MATCH: rdata = matchVal[chIdx];
          REG_CTRL:  rdata = CNT_W'(ctrl[chIdx]);
          default:   rdata = '0;
        endcase
      end
    end
  end

  assign status = statusQ;
  assign irq    = irqQ;

  for (genvar k = 0; k < NUM_CH; k++) begin : gStat
    // R6: an enabled match sets the status bit
    assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
      (matchEvt[k] && enQ[k]) |=> statusQ[k]);
    // R10: a clear without a coinciding match clears the bit
    assert_w1c_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && (addr == STAT_ADDR) && wdata[FIRST_CH+k] && !matchEvt[k]) |=> !statusQ[k]);
  end

  // R10: interrupt follows the status bits
  assert_irq_level_R10: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqQ == (statusQ != '0)));
endmodule

// File: rtl/mcb_bank.sv
module mcb_bank
  import mcb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [7:0]        addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              tick32k,
  input  logic              tick1k,
  input  logic              tick1hz,
  input  logic              tick1m,
  input  logic              tickExt,
  output logic [7:0]        status,
  output logic              irq
);
  strobes_t                      strb;
  logic [NUM_SEL-1:0]            srcTick;
  logic [NUM_CH-1:0][CNT_W-1:0]  cnt;
  logic [NUM_CH-1:0][CNT_W-1:0]  matchVal;
  logic [NUM_CH-1:0][CTRL_W-1:0] ctrl;
  logic [NUM_CH-1:0]             matchEvt;

  // select codes 0, 6, 7 give no tick
  assign srcTick = {2'b00, tickExt, tick1m, tick1hz, tick1k, tick32k, 1'b0};

  mcb_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .addr     (addr),
    .wdata    (wdata),
    .cnt      (cnt),
    .matchVal (matchVal),
    .ctrl     (ctrl),
    .matchEvt (matchEvt),
    .strb     (strb),
    .rdata    (rdata),
    .status   (status),
    .irq      (irq)
  );

  mcb_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .srcTick  (srcTick),
    .cnt      (cnt),
    .matchVal (matchVal),
    .ctrl     (ctrl),
    .matchEvt (matchEvt)
  );
endmodule

// File: tb/sim_mcb_bank.sv
module sim_mcb_bank;
  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn, rdEn;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        tick32k, tick1k, tick1hz, tick1m, tickExt;
  logic [7:0]  status;
  logic        irq;
  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #5 clk = ~clk;

  mcb_bank u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick32k(tick32k), .tick1k(tick1k),
    .tick1hz(tick1hz), .tick1m(tick1m), .tickExt(tickExt),
    .status(status), .irq(irq)
  );

  function automatic logic [7:0] cA(input int n); return 8'(8'h40 + 4*(n-4)); endfunction
  function automatic logic [7:0] mA(input int n); return 8'(8'h80 + 4*(n-4)); endfunction
  function automatic logic [7:0] kA(input int n); return 8'(8'hC0 + 4*(n-4)); endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rdEn = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // which: 0 32k, 1 1k, 2 1Hz, 3 1MHz, 4 ext, 5 all
  task automatic pulse(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      tick32k = (which == 0) || (which == 5);
      tick1k  = (which == 1) || (which == 5);
      tick1hz = (which == 2) || (which == 5);
      tick1m  = (which == 3) || (which == 5);
      tickExt = (which == 4) || (which == 5);
      @(negedge clk);
      {tick32k, tick1k, tick1hz, tick1m, tickExt} = '0;
    end
  endtask

  task automatic clean();
    for (int n = 4; n < 12; n++) begin
      wr(kA(n), 0);
      wr(cA(n), 0);
    end
    wr(8'h14, 32'hFFF);
  endtask

  task automatic t_reset();
    rd(cA(4), v);  chk("R2 counter 4", v, 0);
    rd(mA(11), v); chk("R2 match 11", v, 0);
    rd(kA(9), v);  chk("R2 control 9", v, 0);
    rd(8'h14, v);  chk("R2 status", v, 0);
    rd(8'h20, v);  chk("R2 snapshot", v, 0);
    chk("R2 irq", 32'(irq), 0);
    wr(8'h1C, 32'hFF0);
    rd(8'h1C, v);  chk("R1 enable readback", v, 32'hFF0);
  endtask

  task automatic t_source();
    wr(kA(4), 1);
    pulse(1, 3); rd(cA(4), v); chk("R3 wrong tick ignored", v, 0);
    pulse(0, 3); rd(cA(4), v); chk("R3 code 1", v, 3);
    wr(kA(4), 4); pulse(3, 2); rd(cA(4), v); chk("R3 code 4", v, 5);
    wr(kA(4), 3); pulse(2, 1); rd(cA(4), v); chk("R3 code 3", v, 6);
    wr(kA(4), 2); pulse(1, 1); rd(cA(4), v); chk("R3 code 2", v, 7);
    wr(kA(4), 5); pulse(4, 1); rd(cA(4), v); chk("R3 code 5", v, 8);
    wr(kA(4), 6); pulse(5, 2); rd(cA(4), v); chk("R3 code 6 stopped", v, 8);
    clean();
  endtask

  task automatic t_mask();
    wr(kA(5), 32'hFFFF_FFFF); rd(kA(5), v); chk("R4 narrow control", v, 32'hFF);
    wr(kA(9), 32'hFFFF_FFFF); rd(kA(9), v); chk("R4 wide control", v, 32'h3FF);
    wr(kA(9), 32'h181); wr(cA(9), 0);
    pulse(0, 2); rd(cA(9), v); chk("R4 halt bit", v, 0);
    wr(kA(9), 32'h81);
    pulse(0, 2); rd(cA(9), v); chk("R4 halt released", v, 2);
    clean();
  endtask

  task automatic t_share();
    wr(kA(4), 1); wr(mA(6), 3);
    pulse(0, 2); rd(8'h14, v); chk("R6 no early match", v & 32'h40, 0);
    pulse(0, 1); rd(8'h14, v); chk("R5 shared compare match", v & 32'h40, 32'h40);
    chk("R10 irq high", 32'(irq), 1);
    rd(cA(6), v); chk("R5 follower counter idle", v, 0);
    rd(cA(4), v); chk("R5 leader counter", v, 3);
    wr(8'h14, 32'h40);
    rd(8'h14, v); chk("R10 w1c clears", v, 0);
    chk("R10 irq low", 32'(irq), 0);
    wr(kA(6), 32'h81); wr(mA(6), 2);
    pulse(0, 2); rd(cA(6), v); chk("R5 own counter", v, 2);
    rd(8'h14, v); chk("R5 own compare match", v & 32'h40, 32'h40);
    clean();
  endtask

  task automatic t_enable();
    wr(8'h1C, 32'hFD0);
    wr(kA(5), 32'h81); wr(mA(5), 1);
    pulse(0, 1); rd(8'h14, v); chk("R6 disabled no status", v & 32'h20, 0);
    wr(8'h1C, 32'hFF0);
    clean();
  endtask

  task automatic t_oneshot();
    wr(kA(5), 32'h81); wr(mA(5), 2);
    pulse(0, 2); rd(8'h14, v); chk("R8 first match", v & 32'h20, 32'h20);
    rd(cA(5), v); chk("R7 no zeroing without bit 3", v, 2);
    wr(8'h14, 32'h20); wr(cA(5), 0);
    pulse(0, 2); rd(8'h14, v); chk("R8 one-shot disarmed", v & 32'h20, 0);
    wr(mA(5), 2); wr(cA(5), 0);
    pulse(0, 2); rd(8'h14, v); chk("R8 rearmed by match write", v & 32'h20, 32'h20);
    clean();
  endtask

  task automatic t_periodic();
    wr(kA(7), 32'hC9); wr(mA(7), 3);
    pulse(0, 2); rd(cA(7), v); chk("R7 counting", v, 2);
    pulse(0, 1); rd(cA(7), v); chk("R7 zeroed on match", v, 0);
    rd(8'h14, v); chk("R8 periodic first", v & 32'h80, 32'h80);
    wr(8'h14, 32'h80);
    pulse(0, 3); rd(8'h14, v); chk("R8 periodic again", v & 32'h80, 32'h80);
    rd(cA(7), v); chk("R7 zeroed again", v, 0);
    clean();
  endtask

  task automatic t_snapshot();
    wr(kA(8), 1); wr(cA(8), 32'h100);
    pulse(0, 5); rd(cA(8), v); chk("R1 counter 8", v, 32'h105);
    wr(kA(8), 0);
    wr(kA(9), 32'h200);
    rd(cA(9), v);
    rd(8'h20, v); chk("R9 snapshot of channel 8", v, 32'h105);
    wr(cA(10), 32'h50);
    rd(cA(11), v);
    rd(8'h20, v); chk("R9 no capture without bit 9", v, 32'h105);
    wr(kA(11), 32'h200);
    rd(cA(11), v);
    rd(8'h20, v); chk("R9 snapshot of channel 10", v, 32'h50);
    clean();
  endtask

  task automatic t_collide();
    wr(kA(5), 32'h81); wr(mA(5), 1);
    pulse(0, 1);
    wr(kA(5), 0);
    wr(kA(4), 32'h81); wr(mA(4), 1);
    // clear bits 4 and 5 while channel 4 matches
    wrEn = 1'b1; addr = 8'h14; wdata = 32'h30; tick32k = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick32k = 1'b0;
    rd(8'h14, v); chk("R10 set wins over clear", v & 32'h30, 32'h10);
    chk("R10 irq held", 32'(irq), 1);
    clean();
  endtask

  task automatic t_cntwrite();
    wr(kA(4), 1);
    wrEn = 1'b1; addr = cA(4); wdata = 32'h1234; tick32k = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tick32k = 1'b0;
    rd(cA(4), v); chk("R11 write wins over tick", v, 32'h1234);
    pulse(0, 1); rd(cA(4), v); chk("R11 counts from loaded value", v, 32'h1235);
    wr(mA(9), 32'hCAFE); rd(mA(9), v); chk("R1 match readback", v, 32'hCAFE);
    clean();
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; rdEn = 1'b0; addr = '0; wdata = '0;
    {tick32k, tick1k, tick1hz, tick1m, tickExt} = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_source();
    t_mask();
    t_share();
    t_enable();
    t_oneshot();
    t_periodic();
    t_snapshot();
    t_collide();
    t_cntwrite();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule